// File: doc/BRIEF.md
# Write-Back Cache Flush Sequencer

This block sits beside a two-way set-associative write-back cache (128 sets and 256-byte lines by default, 64 KB in all). It writes dirty lines back to main memory so that a display engine reading memory directly sees coherent data. It does not hold cache data. For each line it takes the tag port for one cycle and reads that line's dirty bit. If the line is dirty, it clears the bit in that same cycle. It then asks the memory side to copy the line out, using a request/acknowledge handshake.

Three things can start a flush:
- A software pulse starts a full pass.
- A vertical-sync pulse starts a full pass, but only while the vsync-flush enable is set.
- A background trickle timer handles a single line at a time, once per `PERIOD` clocks (1024 by default).

A full pass visits every line in ascending order: set 0 way 0, set 0 way 1, set 1 way 0, and so on. The CPU is stalled only in the cycles in which the sequencer owns the tag port. It runs freely while a write-back is in flight.

The controller has three states:
- `ST_IDLE`: nothing to do.
- `ST_SCAN`: owns the tag port and examines one line.
- `ST_WB`: waits for the memory side to accept a write-back.

The transitions are:
- IDLE→SCAN on a trigger, on a pending trigger, or on a trickle tick.
- SCAN→WB when the line is dirty.
- SCAN→SCAN when the line is clean and is not the last line.
- WB→SCAN on acknowledge when the line is not the last.
- SCAN/WB→IDLE once the final line is handled.
- SCAN/WB→SCAN at line 0 when a trigger is pending at that point (restart).

Top module: `fl_flush_seq`

## Requirements
- R1: After reset `busy`, `tag_own`, `tag_clr` and `wb_req` are all low.
- R2: A full pass handles lines in ascending order of line number L = set×WAYS + way, from 0 to the last line, and starts with line 0 in the cycle after the trigger is sampled.
- R3: Each line examined occupies exactly one cycle with `tag_own` high. `tag_own` is low in every cycle in which `wb_req` is high.
- R4: In the scan cycle of a dirty line, `tag_clr` is high. In the next cycle `wb_req` rises with that line's set and way, which stay stable until `wb_ack` is sampled high.
- R5: `busy` is high from the cycle after a full-pass trigger until the last line is handled. A pass therefore takes LINES cycles plus the cycles spent waiting on each write-back.
- R6: `vsync` starts a full pass only while `vsync_flush_en` is 1. Otherwise it has no effect.
- R7: A trigger that arrives during a pass is held as pending. A new pass then begins at line 0 directly after the last line, and `busy` stays high in between.
- R8: Several triggers that arrive during one pass produce only one extra pass.
- R9: While `trickle_en` is 1, one line is handled every `PERIOD` clocks, at a pointer that advances by one line each time and wraps after the last line. Trickle work never raises `busy`.
- R10: A trickle tick that comes while the sequencer is not idle, or in the same cycle as a full-pass trigger, is dropped, and the trickle pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_flush | input | 1 | Software full-flush pulse |
| vsync | input | 1 | Display vertical-sync pulse |
| vsync_flush_en | input | 1 | Lets `vsync` start a full pass |
| trickle_en | input | 1 | Enables the periodic single-line flush |
| tag_own | output | 1 | Sequencer owns the tag port; the CPU must stall |
| tag_set | output | SET_W | Set index presented to the tag array |
| tag_way | output | WAY_W | Way presented to the tag array |
| tag_dirty | input | 1 | Dirty bit of the addressed line (same-cycle read) |
| tag_clr | output | 1 | Clear the dirty bit of the addressed line at this edge |
| wb_req | output | 1 | Line write-back request |
| wb_set | output | SET_W | Set of the line to write back |
| wb_way | output | WAY_W | Way of the line to write back |
| wb_ack | input | 1 | Memory side accepts the write-back |
| busy | output | 1 | A full pass is in progress |

## Verification
The bound checker watches the local rules on every cycle:
- Scanning moves forward one line at a time.
- A pass opens at line 0.
- A cleared line is requested in the next cycle.
- A request holds its address until it is acknowledged.
- The port is never owned during a write-back.

Other behaviour spans many cycles and only the bench scenarios can show it: total pass length, the collapsing of pending triggers, vsync gating, trickle pointer wrap, and dropped ticks. The bench checks these through the order of the write-back stream, `busy` and `tag_own` cycle counts, and the bench's own dirty-bit model.

// File: rtl/fl_pkg.sv
package fl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WB   = 2'd2
    } fl_state_e;
endpackage

// File: rtl/fl_line_walker.sv
// Line index counter: restarts at zero, steps by one, wraps naturally.
module fl_line_walker #(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              step,
    output logic [LINE_W-1:0] idx
);
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (restart) idx <= '0;
        else if (step)    idx <= idx + LINE_W'(1);
    end
endmodule

// File: rtl/fl_trickle_timer.sv
// Emits one tick every PERIOD enabled cycles; the count restarts when disabled.
module fl_trickle_timer #(
    parameter  int PERIOD = 1024,
    localparam int CNT_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !enable) cnt <= '0;
        else if (cnt == LAST)  cnt <= '0;
        else                   cnt <= cnt + CNT_W'(1);
    end

    assign tick = enable && (cnt == LAST);
endmodule

// File: rtl/fl_flush_seq.sv
module fl_flush_seq
    import fl_pkg::*;
#(
    parameter  int SETS   = 128,
    parameter  int WAYS   = 2,
    parameter  int PERIOD = 1024,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int LINE_W = SET_W + WAY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_flush,
    input  logic             vsync,
    input  logic             vsync_flush_en,
    input  logic             trickle_en,
    output logic             tag_own,
    output logic [SET_W-1:0] tag_set,
    output logic [WAY_W-1:0] tag_way,
    input  logic             tag_dirty,
    output logic             tag_clr,
    output logic             wb_req,
    output logic [SET_W-1:0] wb_set,
    output logic [WAY_W-1:0] wb_way,
    input  logic             wb_ack,
    output logic             busy
);
    fl_state_e         st_q, st_d;
    logic              full_q, full_d;
    logic              pend_q, pend_d;
    logic [LINE_W-1:0] walk_idx, trk_idx, cur, wb_line_q;
    logic              walk_last, trig, tick, line_done;
    logic              start_full, walk_step, trk_step;

    // Full-pass walker and trickle pointer share one counter design.
    fl_line_walker #(.LINE_W(LINE_W)) u_walk (
        .clk(clk), .rst_n(rst_n), .restart(start_full), .step(walk_step), .idx(walk_idx)
    );
    fl_line_walker #(.LINE_W(LINE_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .restart(1'b0), .step(trk_step), .idx(trk_idx)
    );
    fl_trickle_timer #(.PERIOD(PERIOD)) u_tmr (
        .clk(clk), .rst_n(rst_n), .enable(trickle_en), .tick(tick)
    );

    assign trig      = sw_flush || (vsync && vsync_flush_en);
    assign walk_last = &walk_idx;
    assign cur       = full_q ? walk_idx : trk_idx;
    assign line_done = ((st_q == ST_SCAN) && !tag_dirty) || ((st_q == ST_WB) && wb_ack);

    // Next-state and sequencing decisions.
    always_comb begin
        st_d       = st_q;
        full_d     = full_q;
        start_full = 1'b0;
        walk_step  = 1'b0;
        trk_step   = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (trig || pend_q) begin
                    st_d = ST_SCAN; full_d = 1'b1; start_full = 1'b1;
                end else if (tick) begin
                    st_d = ST_SCAN; full_d = 1'b0;
                end
            end
            ST_SCAN, ST_WB: begin
                if ((st_q == ST_SCAN) && tag_dirty) begin
                    st_d = ST_WB;
                end else if (line_done) begin
                    if (full_q && !walk_last) begin
                        st_d = ST_SCAN; walk_step = 1'b1;
                    end else begin
                        trk_step = !full_q;
                        if (trig || pend_q) begin
                            st_d = ST_SCAN; full_d = 1'b1; start_full = 1'b1;
                        end else begin
                            st_d = ST_IDLE; full_d = 1'b0;
                        end
                    end
                end
            end
            default: begin
                st_d = ST_IDLE; full_d = 1'b0;
            end
        endcase
        pend_d = start_full ? 1'b0 : (pend_q || (trig && (st_q != ST_IDLE)));
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            full_q    <= 1'b0;
            pend_q    <= 1'b0;
            wb_line_q <= '0;
        end else begin
            st_q   <= st_d;
            full_q <= full_d;
            pend_q <= pend_d;
            if ((st_q == ST_SCAN) && tag_dirty) wb_line_q <= cur;
        end
    end

    // Outputs.
    always_comb begin
        tag_own = (st_q == ST_SCAN);
        tag_set = cur[LINE_W-1:WAY_W];
        tag_way = cur[WAY_W-1:0];
        tag_clr = tag_own && tag_dirty;
        wb_req  = (st_q == ST_WB);
        wb_set  = wb_line_q[LINE_W-1:WAY_W];
        wb_way  = wb_line_q[WAY_W-1:0];
        busy    = full_q && (st_q != ST_IDLE);
    end
endmodule

// File: rtl/fl_flush_chk.sv
module fl_flush_chk #(
    parameter  int SET_W  = 7,
    parameter  int WAY_W  = 1,
    localparam int LINE_W = SET_W + WAY_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tag_own,
    input logic [SET_W-1:0] tag_set,
    input logic [WAY_W-1:0] tag_way,
    input logic             tag_dirty,
    input logic             tag_clr,
    input logic             wb_req,
    input logic [SET_W-1:0] wb_set,
    input logic [WAY_W-1:0] wb_way,
    input logic             wb_ack,
    input logic             busy
);
    logic [LINE_W-1:0] line_now, wb_line;
    assign line_now = {tag_set, tag_way};
    assign wb_line  = {wb_set, wb_way};

    a_r2_next_line: assert property (@(posedge clk) disable iff (!rst_n)
        busy && tag_own && !tag_dirty && !(&line_now)
        |=> tag_own && (line_now == $past(line_now) + LINE_W'(1)));

    a_r2_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> tag_own && (line_now == '0));

    a_r3_wb_no_own: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !tag_own);

    a_r4_clr_then_wb: assert property (@(posedge clk) disable iff (!rst_n)
        tag_clr |=> wb_req && (wb_line == $past(line_now)));

    a_r4_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req && !wb_ack |=> wb_req && $stable(wb_set) && $stable(wb_way));
endmodule

bind fl_flush_seq fl_flush_chk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tag_own(tag_own), .tag_set(tag_set), .tag_way(tag_way),
    .tag_dirty(tag_dirty), .tag_clr(tag_clr), .wb_req(wb_req), .wb_set(wb_set),
    .wb_way(wb_way), .wb_ack(wb_ack), .busy(busy)
);

// File: tb/sim_fl_flush_seq.sv
`timescale 1ns/1ps
module sim_fl_flush_seq;
    localparam int SETS = 4, WAYS = 2, PERIOD = 16, LAT = 2;
    localparam int LINES = SETS * WAYS;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sw_flush = 0, vsync = 0, vsync_flush_en = 0, trickle_en = 0;
    logic tag_own, tag_dirty, tag_clr, wb_req, wb_ack, busy;
    logic [1:0] tag_set, wb_set;
    logic [0:0] tag_way, wb_way;

    logic [LINES-1:0] dmap, mark;
    int wcnt, busy_cnt, own_cnt, n_tests, n_fail;
    int exp_q[$];
    bit done;

    always #4 clk = ~clk;

    fl_flush_seq #(.SETS(SETS), .WAYS(WAYS), .PERIOD(PERIOD)) u0 (
        .clk(clk), .rst_n(rst_n), .sw_flush(sw_flush), .vsync(vsync),
        .vsync_flush_en(vsync_flush_en), .trickle_en(trickle_en),
        .tag_own(tag_own), .tag_set(tag_set), .tag_way(tag_way), .tag_dirty(tag_dirty),
        .tag_clr(tag_clr), .wb_req(wb_req), .wb_set(wb_set), .wb_way(wb_way),
        .wb_ack(wb_ack), .busy(busy)
    );

    // Tag-array model and memory-side model.
    assign tag_dirty = dmap[{tag_set, tag_way}];
    assign wb_ack    = wb_req && (wcnt == LAT);
    always @(posedge clk) begin
        if (!rst_n) begin
            dmap <= '0; wcnt <= 0;
        end else begin
            logic [LINES-1:0] clr;
            clr = '0;
            if (tag_clr) clr[{tag_set, tag_way}] = 1'b1;
            dmap <= (dmap & ~clr) | mark;
            wcnt <= (wb_req && !wb_ack) ? wcnt + 1 : 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected write-backs and compares, counts cycles.
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cnt++;
            if (tag_own) own_cnt++;
            if (wb_req && wb_ack) begin
                if (exp_q.size() == 0) check(0, "R2/R4 unexpected write-back", int'({wb_set, wb_way}), -1);
                else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'({wb_set, wb_way}) == e, "R2/R4 write-back line", int'({wb_set, wb_way}), e);
                end
            end
        end
    end

    // Driver helpers.
    task automatic expect_lines(input logic [LINES-1:0] m);
        for (int i = 0; i < LINES; i++) if (m[i]) exp_q.push_back(i);
    endtask
    task automatic make_dirty(input logic [LINES-1:0] m);
        @(negedge clk); mark = m; @(negedge clk); mark = '0;
    endtask
    task automatic pulse_sw();
        @(negedge clk); sw_flush = 1; @(negedge clk); sw_flush = 0;
    endtask
    task automatic pulse_vs();
        @(negedge clk); vsync = 1; @(negedge clk); vsync = 0;
    endtask
    task automatic clr_counts();
        busy_cnt = 0; own_cnt = 0;
    endtask
    task automatic wait_idle();
        @(negedge clk);
        for (int k = 0; k < 2000 && busy; k++) @(negedge clk);
    endtask

    initial begin
        mark = '0;
        repeat (3) @(negedge clk);
        check(!busy && !tag_own && !tag_clr && !wb_req, "R1 reset outputs", int'({busy, tag_own, wb_req}), 0);
        rst_n = 1;

        // R2 R3 R4 R5: full software pass with a mixed pattern
        make_dirty(8'b1010_0101);
        expect_lines(8'b1010_0101);
        clr_counts();
        pulse_sw();
        wait_idle();
        check(busy_cnt == LINES + 4 * (LAT + 1), "R5 pass length", busy_cnt, LINES + 4 * (LAT + 1));
        check(own_cnt == LINES, "R3 one owned cycle per line", own_cnt, LINES);
        check(dmap == '0, "R4 dirty bits cleared", int'(dmap), 0);
        check(exp_q.size() == 0, "R2 all write-backs seen", exp_q.size(), 0);

        // R6: vsync gated off, then on
        make_dirty(8'b1000_0000);
        clr_counts();
        pulse_vs();
        repeat (10) @(negedge clk);
        check(busy_cnt == 0 && own_cnt == 0, "R6 vsync ignored when disabled", busy_cnt + own_cnt, 0);
        check(dmap == 8'b1000_0000, "R6 line still dirty", int'(dmap), 128);
        vsync_flush_en = 1;
        expect_lines(8'b1000_0000);
        clr_counts();
        pulse_vs();
        wait_idle();
        check(busy_cnt == LINES + (LAT + 1), "R6 vsync pass length", busy_cnt, LINES + LAT + 1);
        check(exp_q.size() == 0, "R6 vsync write-back seen", exp_q.size(), 0);

        // R7 R8: two triggers during a pass collapse into one extra pass
        make_dirty('1);
        expect_lines('1);
        clr_counts();
        pulse_sw();
        repeat (3) @(negedge clk);
        pulse_sw();
        repeat (3) @(negedge clk);
        pulse_vs();
        wait_idle();
        check(busy_cnt == 2 * LINES + LINES * (LAT + 1), "R7 R8 pending pass length", busy_cnt, 2 * LINES + LINES * (LAT + 1));
        check(own_cnt == 2 * LINES, "R8 exactly two passes", own_cnt, 2 * LINES);
        vsync_flush_en = 0;

        // R9: trickle walks lines 0..7 then wraps
        make_dirty(8'b0000_1001);
        expect_lines(8'b0000_1001);
        clr_counts();
        @(negedge clk); trickle_en = 1;
        repeat (LINES * PERIOD + 4) @(negedge clk);
        check(own_cnt == LINES, "R9 one line per period", own_cnt, LINES);
        check(busy_cnt == 0, "R9 trickle keeps busy low", busy_cnt, 0);
        check(exp_q.size() == 0, "R9 trickle write-backs", exp_q.size(), 0);
        mark = 8'b0000_0001; @(negedge clk); mark = '0;
        expect_lines(8'b0000_0001);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0 && dmap == '0, "R9 pointer wraps to line 0", exp_q.size(), 0);
        trickle_en = 0;

        // R10: ticks during a long pass are dropped; pointer stays at line 1
        make_dirty('1);
        expect_lines('1);
        @(negedge clk); trickle_en = 1; sw_flush = 1;
        @(negedge clk); sw_flush = 0;
        wait_idle();
        check(exp_q.size() == 0, "R10 pass completed", exp_q.size(), 0);
        make_dirty(8'b0000_0010);
        expect_lines(8'b0000_0010);
        repeat (PERIOD + 8) @(negedge clk);
        check(exp_q.size() == 0 && dmap == '0, "R10 trickle resumes at line 1", int'(dmap), 0);
        trickle_en = 0;

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule